// File: doc/BRIEF.md
# Cyclic converter decision-weight reconstructor

A cyclic converter resolves its input one step at a time. Each step yields a ternary comparator decision and an amplified residue that feeds the next step. This block turns that stream of decisions into a signed binary output code. Decision k is weighted by the k-th entry of a rewritable weight table. In normal use the entries hold successive powers of the reciprocal of the estimated stage gain. That gain is kept a little under two, so that several decision paths lead to the same valid code. With a table, the radix can be corrected in the digital domain instead of being trimmed in the analog one.

A conversion opens with a start strobe that carries the number of decisions to expect. The block then accepts one decision per valid beat and adds the signed, weighted term into a wide accumulator. After the last decision it rounds the sum to a 16-bit signed code, clamps it to that range, and presents it with a single-clock valid pulse. A calibration engine that runs in the background rewrites the weights through a shadow bank. The shadow bank is copied into the working bank only when a conversion starts, so every conversion uses one consistent set of weights.

Top module: `cyclic_recon`

## Requirements
- R1: `dec` is decoded as 2'b01 = +1, 2'b11 = -1 and 2'b00 = 0. The k-th decision accepted since start (k counted from 0) adds d times working weight k to a signed accumulator. The accumulator is cleared at start.
- R2: The output code is floor((acc + 512) / 1024): the sum is scaled by 2^-10 and rounded half up. A sum of +512 gives 1, -512 gives 0, +1536 gives 2 and -1536 gives -1.
- R3: If the rounded value lies outside the signed 16-bit range, the output takes 32767 (above the range) or -32768 (below it).
- R4: `wr_en` writes `wr_data` into shadow entry `wr_idx`. `wr_commit` marks the shadow as pending. A start while a commit is pending copies the whole shadow into the working bank at that edge. Writes that are not committed, and commits made during a conversion, leave that conversion's weights unchanged.
- R5: After reset both banks hold the binary weights 2^(23-k). One +1 decision then gives 8192, and twenty +1 decisions give 16384.
- R6: `out_valid` is high for exactly one clock. That clock follows the edge at which the last decision was accepted. `out_code` changes only together with `out_valid` and holds its value in between.
- R7: Decisions are ignored while no conversion is open, and also in the start cycle itself. A start during a conversion abandons it without producing an output and begins a new conversion.
- R8: The code 2'b10 is an invalid decision. It contributes zero but still uses up its cycle slot, and `dec_err` pulses on the following clock.
- R9: An `ncyc` of 0, or any value above 20, runs a 20-decision conversion.
- R10: A beat with `dec_valid` low neither advances the cycle index nor changes the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a conversion; swaps in committed weights |
| ncyc | input | 5 | Decisions in this conversion (0 or >20 means 20) |
| dec_valid | input | 1 | A decision is present on `dec` |
| dec | input | 2 | Ternary decision code |
| wr_en | input | 1 | Write one shadow weight |
| wr_idx | input | 5 | Shadow entry to write |
| wr_data | input | 24 | Unsigned weight, 24 fractional bits |
| wr_commit | input | 1 | Mark the shadow bank for swap at next start |
| out_valid | output | 1 | One-clock result strobe |
| out_code | output | 16 | Signed rounded, clamped result |
| dec_err | output | 1 | An invalid decision code was accepted |

## Verification
The main path is run with several decision patterns: all-zero, all +1, all -1, alternating signs, short sparse patterns, and random ternary sequences. The random sequences run against a table of non-binary weights with a gain of 1.92 and are compared with a model. All-zero catches a stale accumulator, the uniform-sign runs catch sign-extension and negation faults, and alternating or random sequences catch wrong weight indexing. Directed runs cover the following cases, each of which separates a specific fault from correct behaviour:
- the binary reset table;
- exact rounding ties;
- clamping at both ends;
- uncommitted writes and commits made during a conversion;
- invalid codes;
- idle and start-cycle decisions;
- aborted conversions;
- stalled beats;
- out-of-range counts.

// File: rtl/cyclic_recon.sv
module cyclic_recon #(
  parameter int NCYC = 20,
  parameter int WW   = 24,
  parameter int AW   = 28,
  parameter int OW   = 16,
  parameter int SH   = 10,
  localparam int CW  = $clog2(NCYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] ncyc,
  input  logic          dec_valid,
  input  logic [1:0]    dec,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_idx,
  input  logic [WW-1:0] wr_data,
  input  logic          wr_commit,
  output logic          out_valid,
  output logic [OW-1:0] out_code,
  output logic          dec_err
);
  localparam int RW = AW - SH;
  localparam logic signed [AW-1:0] HALF = AW'(1) << (SH - 1);
  localparam logic signed [RW-1:0] QMAX = RW'((1 << (OW - 1)) - 1);
  localparam logic signed [RW-1:0] QMIN = ~QMAX;

  logic [NCYC-1:0][WW-1:0] wsh, wact;
  logic                    pend, busy;
  logic [CW-1:0]           idx, last;
  logic signed [AW-1:0]    acc, term;

  wire accept = busy && dec_valid && !start;
  wire fin    = accept && (idx == last);
  wire [CW-1:0] nsel = (ncyc == '0 || ncyc > CW'(NCYC)) ? CW'(NCYC) : ncyc;
  wire signed [AW-1:0] wext = $signed({{(AW - WW){1'b0}}, wact[idx]});

  always_comb begin
    case (dec)
      2'b01:   term = wext;
      2'b11:   term = -wext;
      default: term = '0;
    endcase
  end

  wire signed [AW-1:0] acc_n = acc + term;
  wire signed [AW-1:0] rnd   = acc_n + HALF;
  wire signed [RW-1:0] q     = rnd[AW-1:SH];
  wire [OW-1:0] sat = (q > QMAX) ? QMAX[OW-1:0] :
                      (q < QMIN) ? QMIN[OW-1:0] : q[OW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NCYC; k++) begin
        wsh[k]  <= WW'(1) << (WW - 1 - k);
        wact[k] <= WW'(1) << (WW - 1 - k);
      end
      pend <= 1'b0;
    end else begin
      if (wr_en && wr_idx < CW'(NCYC)) wsh[wr_idx] <= wr_data;
      if (start && pend) wact <= wsh;
      pend <= (pend && !start) || wr_commit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx       <= '0;
      last      <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_code  <= '0;
      dec_err   <= 1'b0;
    end else begin
      out_valid <= fin;
      dec_err   <= accept && (dec == 2'b10);
      if (fin) out_code <= sat;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        last <= nsel - 1'b1;
        acc  <= '0;
      end else if (accept) begin
        acc <= acc_n;
        idx <= idx + 1'b1;
        if (idx == last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cyclic_recon_chk.sv
module cyclic_recon_chk #(
  parameter int NCYC = 20,
  parameter int WW   = 24,
  parameter int OW   = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    dec_valid,
  input logic [1:0]              dec,
  input logic                    busy,
  input logic [NCYC-1:0][WW-1:0] wact,
  input logic                    out_valid,
  input logic [OW-1:0]           out_code,
  input logic                    dec_err
);
  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_code));

  assert_after_decision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(dec_valid && busy && !start));

  assert_idle_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || start) |=> !out_valid);

  assert_err_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> $past(dec_valid && dec == 2'b10));

  assert_weights_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(wact));
endmodule

bind cyclic_recon cyclic_recon_chk #(.NCYC(NCYC), .WW(WW), .OW(OW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .dec_valid(dec_valid), .dec(dec),
  .busy(busy), .wact(wact), .out_valid(out_valid), .out_code(out_code),
  .dec_err(dec_err)
);

// File: tb/cyclic_recon_tb_top.sv
module cyclic_recon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 20;

  logic clk = 1'b0;
  logic rst_n, start, dec_valid, wr_en, wr_commit;
  logic [4:0] ncyc, wr_idx;
  logic [1:0] dec;
  logic [23:0] wr_data;
  logic out_valid, dec_err;
  logic [15:0] out_code;

  int n_run = 0, n_fail = 0, cyc = 0;
  longint m_sh[N], m_act[N];
  bit m_pend = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cyclic_recon dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ncyc(ncyc), .dec_valid(dec_valid),
    .dec(dec), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_commit(wr_commit), .out_valid(out_valid), .out_code(out_code),
    .dec_err(dec_err)
  );

  localparam int VN = 6;
  localparam int V_N [VN] = '{20, 20, 20, 20, 16, 7};
  localparam logic [39:0] V_D [VN] = '{40'h00_0000_0000, 40'h55_5555_5555,
    40'hFF_FFFF_FFFF, 40'hDD_DDDD_DDDD, 40'h00_F1D4_C735, 40'h00_0000_3D17};

  task automatic chk(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model(int n, logic [39:0] d);
    longint acc = 0;
    longint r;
    for (int k = 0; k < n; k++) begin
      if (d[2*k +: 2] == 2'b01) acc += m_act[k];
      else if (d[2*k +: 2] == 2'b11) acc -= m_act[k];
    end
    r = (acc + 512) >>> 10;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic write_w(int i, longint v, bit com);
    wr_en = 1; wr_idx = 5'(i); wr_data = 24'(v); wr_commit = com;
    @(negedge clk);
    wr_en = 0; wr_commit = 0;
    m_sh[i] = v;
    if (com) m_pend = 1;
  endtask

  task automatic run_conv(int n, logic [39:0] d, bit gaps, bit junk, int upd_k,
                          longint upd_v, string tag, output int got);
    int ne = (n == 0 || n > N) ? N : n;
    int exp;
    start = 1; ncyc = 5'(n);
    if (junk) begin dec_valid = 1; dec = 2'b01; end
    @(negedge clk);
    start = 0; dec_valid = 0;
    if (m_pend) begin m_act = m_sh; m_pend = 0; end
    exp = model(ne, d);
    for (int k = 0; k < ne; k++) begin
      if (gaps && (k % 2 == 1)) begin
        dec_valid = 0; dec = 2'b01;
        @(negedge clk);
      end
      dec_valid = 1; dec = d[2*k +: 2];
      if (k == upd_k) begin
        wr_en = 1; wr_idx = 0; wr_data = 24'(upd_v); wr_commit = 1;
      end
      @(negedge clk);
      wr_en = 0; wr_commit = 0;
      if (k == upd_k) begin m_sh[0] = upd_v; m_pend = 1; end
      chk({tag, " R8 dec_err"}, longint'(dec_err), longint'(d[2*k +: 2] == 2'b10));
      chk({tag, " R6 out_valid timing"}, longint'(out_valid), longint'(k == ne - 1));
    end
    got = int'($signed(out_code));
    chk({tag, " code vs model"}, got, exp);
    dec = 2'b01;
    @(negedge clk);
    dec_valid = 0;
    chk({tag, " R6 single pulse"}, longint'(out_valid), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int got;
    real g;
    longint gw[N];
    rst_n = 0; start = 0; ncyc = 0; dec_valid = 0; dec = 0;
    wr_en = 0; wr_idx = 0; wr_data = 0; wr_commit = 0;
    for (int k = 0; k < N; k++) begin
      m_sh[k] = longint'(1) << (23 - k);
      m_act[k] = m_sh[k];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6 reset out_valid", longint'(out_valid), 0);
    chk("R8 reset dec_err", longint'(dec_err), 0);
    chk("R6 reset out_code", longint'(out_code), 0);

    run_conv(1, 40'h1, 0, 0, -1, 0, "R5 single +1", got);
    chk("R5 binary single", got, 8192);
    run_conv(20, 40'h55_5555_5555, 0, 0, -1, 0, "R5 all +1", got);
    chk("R5 binary twenty", got, 16384);
    run_conv(1, 40'h3, 0, 0, -1, 0, "R1 single -1", got);
    chk("R1 binary minus", got, -8192);
    run_conv(0, 40'h55_5555_5555, 0, 0, -1, 0, "R9 ncyc zero", got);
    chk("R9 zero means 20", got, 16384);
    run_conv(25, 40'h55_5555_5555, 0, 0, -1, 0, "R9 ncyc 25", got);
    chk("R9 above means 20", got, 16384);
    run_conv(1, 40'h0, 0, 1, -1, 0, "R7 start-cycle junk", got);
    chk("R7 start cycle ignored", got, 0);

    g = 16777216.0;
    for (int k = 0; k < N; k++) begin
      g = g / 1.92;
      gw[k] = longint'($rtoi(g + 0.5));
      write_w(k, gw[k], 0);
    end
    run_conv(1, 40'h1, 0, 0, -1, 0, "R4 uncommitted", got);
    chk("R4 uncommitted writes unused", got, 8192);
    wr_commit = 1; @(negedge clk); wr_commit = 0; m_pend = 1;

    for (int v = 0; v < VN; v++)
      run_conv(V_N[v], V_D[v], 0, 0, -1, 0, "R1 vector", got);
    for (int t = 0; t < 24; t++) begin
      logic [39:0] d = '0;
      for (int k = 0; k < N; k++) begin
        int r = int'($urandom % 3);
        d[2*k +: 2] = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
      end
      run_conv(1 + int'($urandom % 20), d, t[0], 0, -1, 0, "R10 random", got);
    end

    run_conv(2, 40'h6, 0, 0, -1, 0, "R8 invalid code", got);
    chk("R8 invalid contributes zero", got, (gw[1] + 512) >>> 10);

    run_conv(20, 40'h55_5555_5555, 0, 0, 5, 0, "R4 mid-conversion commit", got);
    run_conv(1, 40'h1, 0, 0, -1, 0, "R4 after swap", got);
    chk("R4 new entry zero", got, 0);

    write_w(0, 512, 1);
    run_conv(1, 40'h1, 0, 0, -1, 0, "R2 tie +", got);
    chk("R2 +512 -> 1", got, 1);
    run_conv(1, 40'h3, 0, 0, -1, 0, "R2 tie -", got);
    chk("R2 -512 -> 0", got, 0);
    write_w(0, 1536, 1);
    run_conv(1, 40'h1, 0, 0, -1, 0, "R2 tie2 +", got);
    chk("R2 +1536 -> 2", got, 2);
    run_conv(1, 40'h3, 0, 0, -1, 0, "R2 tie2 -", got);
    chk("R2 -1536 -> -1", got, -1);

    for (int k = 0; k < N; k++) write_w(k, longint'(1) << 22, k == N - 1);
    run_conv(20, 40'h55_5555_5555, 0, 0, -1, 0, "R3 clamp high", got);
    chk("R3 clamp high", got, 32767);
    run_conv(20, 40'hFF_FFFF_FFFF, 0, 0, -1, 0, "R3 clamp low", got);
    chk("R3 clamp low", got, -32768);

    start = 1; ncyc = 20;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 3; k++) begin
      dec_valid = 1; dec = 2'b01;
      @(negedge clk);
      chk("R7 aborted no output", longint'(out_valid), 0);
    end
    dec_valid = 0;
    run_conv(1, 40'h3, 0, 0, -1, 0, "R7 restart", got);
    chk("R7 restart only new", got, -4096);
    for (int k = 0; k < 3; k++) begin
      dec_valid = 1; dec = 2'b01;
      @(negedge clk);
      chk("R7 idle decisions ignored", longint'(out_valid), 0);
    end
    dec_valid = 0;
    chk("R6 code held while idle", longint'($signed(out_code)), -4096);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule